// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache

This block sits inside the instruction-memory wrapper of a pipelined processor and serves instruction fetches. The fetch stage presents a 32-bit byte address; if the addressed word is held in one of the cache lines, the instruction comes back in the same cycle. The cache holds sixteen 32-bit words, arranged as four lines of four words. It is read-only, so it has no write path.

On a miss the block stalls the fetch stage. It reads the whole four-word block from a word-addressed backing memory, one word per cycle, starting at word 0 of the block. It then marks the line valid with the new tag, and the requested instruction is returned in the first cycle the stall is gone. The backing memory is read combinationally: the address is driven and the data is taken in the same cycle.

The fetch side uses a valid/ready pair. `fetch_ready` low while `fetch_valid` is high is the pipeline stall. It is back-pressure: the fetch stage must keep `fetch_valid` high and `fetch_addr` unchanged until it sees `fetch_ready` high. The access completes on that cycle. While `fetch_valid` is low, the cache is idle and does not read memory.

Top module: `fetch_icache`

## Requirements
- R1: After reset every line is invalid, so the first fetch to any line is a miss.
- R2: A fetch that hits returns, in the same cycle, `fetch_ready` high and `fetch_word` equal to backing-memory word `fetch_addr[31:2]`, with no stall cycle.
- R3: A fetch that misses holds `fetch_ready` low for exactly four consecutive cycles. In the fifth cycle `fetch_ready` is high and the correct word is delivered.
- R4: During a miss, `mem_rd_en` is high in each of the four stall cycles and nowhere else. `mem_addr` goes through `{fetch_addr[31:4], k}` for k = 0, 1, 2, 3, in that order.
- R5: Once a block has been filled, fetches to its other three words hit without a stall.
- R6: The line index is byte-address bits 5..4, the word select is bits 3..2, and the tag is bits 31..6. Two blocks with the same index and different tags evict each other, so alternating between them misses each time.
- R7: Byte-address bits 1..0 are ignored. A fetch with nonzero low bits returns the same word as the aligned address.
- R8: While `fetch_valid` is low and no fill is running, `fetch_ready` is high and `mem_rd_en` is low.
- R9: The four lines are independent. After four blocks with distinct indices are filled, all sixteen of their words hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Access completes this cycle; low with valid means stall |
| fetch_word | output | 32 | Instruction word, meaningful when valid and ready |
| mem_rd_en | output | 1 | Backing-memory read strobe during a fill |
| mem_addr | output | 30 | Backing-memory word address |
| mem_rdata | input | 32 | Backing-memory word, same-cycle read |

## Verification
The properties assume that the fetch stage respects the back-pressure rule: `fetch_valid` and `fetch_addr` stay unchanged while `fetch_ready` is low. They also assume that no request is raised while reset is asserted. The stall-length and read-sequence checks depend on both. The bench's fetch task drives a request after a falling edge and keeps it until `fetch_ready` is seen high. Idle gaps are inserted only between completed accesses. Random addresses are drawn from a few tags so that hits, conflict misses and refills all occur.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;

  // packed line: valid at the top, then tag, then word 0 down to word N-1
  function automatic int line_bits(input int tag_w, input int words, input int data_w);
    return 1 + tag_w + words * data_w;
  endfunction

endpackage

// File: rtl/icache_addr_split.sv
`timescale 1ns/1ps
module icache_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TAG_W-1:0]  tag,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  wsel
);
  logic [1:0] unused_byte_bits;

  assign unused_byte_bits = addr[1:0];
  assign wsel = addr[OFF_W+1:2];
  assign idx  = addr[IDX_W+OFF_W+1:OFF_W+2];
  assign tag  = addr[ADDR_W-1:ADDR_W-TAG_W];
endmodule

// File: rtl/icache_line_store.sv
`timescale 1ns/1ps
module icache_line_store #(
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 26,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = icache_pkg::line_bits(TAG_W, WORDS, DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              inval_en,
  input  logic              word_en,
  input  logic [OFF_W-1:0]  word_sel,
  input  logic [DATA_W-1:0] word_data,
  input  logic              commit_en,
  input  logic [TAG_W-1:0]  commit_tag
);
  localparam int VALID_BIT = LINE_W - 1;
  localparam int TAG_TOP   = LINE_W - 2;

  logic [LINE_W-1:0] line_rd [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [LINE_W-1:0] q;
    logic              sel;

    assign sel = (wr_idx == IDX_W'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel) begin
        if (inval_en) q[VALID_BIT] <= 1'b0;
        for (int w = 0; w < WORDS; w++) begin
          if (word_en && word_sel == OFF_W'(w))
            q[(WORDS-1-w)*DATA_W +: DATA_W] <= word_data;
        end
        if (commit_en) begin
          q[VALID_BIT]                <= 1'b1;
          q[TAG_TOP -: TAG_W]         <= commit_tag;
        end
      end
    end

    assign line_rd[l] = q;
  end

  assign rd_line = line_rd[rd_idx];
endmodule

// File: rtl/icache_fill_ctrl.sv
`timescale 1ns/1ps
module icache_fill_ctrl #(
  parameter int TAG_W = 26,
  parameter int IDX_W = 2,
  parameter int OFF_W = 2,
  localparam int WORDS = 1 << OFF_W,
  localparam int MA_W  = TAG_W + IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [IDX_W-1:0] req_idx,
  output logic             busy,
  output logic             mem_rd_en,
  output logic [MA_W-1:0]  mem_addr,
  output logic [IDX_W-1:0] wr_idx,
  output logic [OFF_W-1:0] wr_sel,
  output logic             inval_en,
  output logic             commit_en,
  output logic [TAG_W-1:0] commit_tag
);
  import icache_pkg::*;

  fill_state_e      state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;
  logic             last;
  logic [TAG_W-1:0] cur_tag;

  assign busy      = (state_q == FILL_BUSY);
  assign start     = !busy && miss;
  assign last      = busy && (cnt_q == OFF_W'(WORDS - 1));
  assign cur_tag   = start ? req_tag : tag_q;
  assign wr_idx    = start ? req_idx : idx_q;
  assign wr_sel    = start ? '0 : cnt_q;
  assign mem_rd_en = start || busy;
  assign mem_addr  = {cur_tag, wr_idx, wr_sel};
  assign inval_en  = start;
  assign commit_en = last;
  assign commit_tag = tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      cnt_q   <= '0;
      tag_q   <= '0;
      idx_q   <= '0;
    end else if (start) begin
      state_q <= FILL_BUSY;
      cnt_q   <= OFF_W'(1);
      tag_q   <= req_tag;
      idx_q   <= req_idx;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) state_q <= FILL_IDLE;
    end
  end
endmodule

// File: rtl/fetch_icache.sv
`timescale 1ns/1ps
module fetch_icache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - 2,
  localparam int MA_W   = ADDR_W - 2,
  localparam int LINE_W = icache_pkg::line_bits(TAG_W, WORDS, DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic [DATA_W-1:0] fetch_word,
  output logic              mem_rd_en,
  output logic [MA_W-1:0]   mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_sel;
  logic [LINE_W-1:0] line;
  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic              hit;
  logic              busy;
  logic [IDX_W-1:0]  wr_idx;
  logic [OFF_W-1:0]  wr_sel;
  logic              inval_en;
  logic              commit_en;
  logic [TAG_W-1:0]  commit_tag;
  logic [DATA_W-1:0] words [WORDS];

  icache_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr(fetch_addr), .tag(req_tag), .idx(req_idx), .wsel(req_sel)
  );

  icache_line_store #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_idx), .rd_line(line),
    .wr_idx(wr_idx), .inval_en(inval_en),
    .word_en(mem_rd_en), .word_sel(wr_sel), .word_data(mem_rdata),
    .commit_en(commit_en), .commit_tag(commit_tag)
  );

  assign line_valid = line[LINE_W-1];
  assign line_tag   = line[LINE_W-2 -: TAG_W];
  assign hit        = line_valid && (line_tag == req_tag);

  icache_fill_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .miss(fetch_valid && !hit),
    .req_tag(req_tag), .req_idx(req_idx),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .wr_idx(wr_idx), .wr_sel(wr_sel),
    .inval_en(inval_en), .commit_en(commit_en), .commit_tag(commit_tag)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = line[(WORDS-1-w)*DATA_W +: DATA_W];
  end

  assign fetch_word  = words[req_sel];
  assign fetch_ready = !busy && (!fetch_valid || hit);
endmodule

// File: rtl/icache_checks.sv
`timescale 1ns/1ps
module icache_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int MA_W  = ADDR_W - 2,
  localparam int CNT_W = $clog2(WORDS) + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_ready,
  input logic [DATA_W-1:0] fetch_word,
  input logic              mem_rd_en,
  input logic [MA_W-1:0]   mem_addr
);
  logic [CNT_W-1:0] low_cnt;
  logic             past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (fetch_valid && !fetch_ready) low_cnt <= low_cnt + 1'b1;
      else                             low_cnt <= '0;
    end
  end

  assert_stall_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CNT_W'(WORDS));

  assert_stall_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready && low_cnt != '0) |-> low_cnt == CNT_W'(WORDS));

  assert_read_in_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !fetch_ready);

  assert_read_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + 1'b1);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && fetch_ready) |-> !mem_rd_en);

  assert_hit_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fetch_valid && fetch_ready && $past(fetch_valid && fetch_ready)
     && fetch_addr == $past(fetch_addr)) |-> fetch_word == $past(fetch_word));
endmodule

bind fetch_icache icache_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
) u_checks (
  .clk(clk), .rst_n(rst_n),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .fetch_ready(fetch_ready), .fetch_word(fetch_word),
  .mem_rd_en(mem_rd_en), .mem_addr(mem_addr)
);

// File: tb/fetch_icache_test.sv
`timescale 1ns/1ps
module fetch_icache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic [31:0] fetch_word;
  logic        mem_rd_en;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [25:0] m_tag [4];
  logic        m_val [4];

  always #10 clk = ~clk;

  fetch_icache uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_word(fetch_word),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mem_fn(input logic [29:0] wa);
    return {wa[13:0], 2'b10, ~wa[15:0]} ^ 32'h5A3C_0F19;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic fetch(input logic [31:0] a, output int stalls);
    logic [1:0] idx;
    bit         exp_hit;
    idx     = a[5:4];
    exp_hit = m_val[idx] && (m_tag[idx] == a[31:6]);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    stalls = 0;
    #2;
    while (!fetch_ready && stalls < 20) begin
      if (stalls < 4) begin
        check(mem_rd_en == 1'b1, "R4", "read strobe in stall", 32'(mem_rd_en), 32'd1);
        check(mem_addr == {a[31:4], 2'(stalls)}, "R4", "fill word address",
              32'(mem_addr), 32'({a[31:4], 2'(stalls)}));
      end
      @(negedge clk); #2;
      stalls++;
    end
    check(stalls == (exp_hit ? 0 : 4), exp_hit ? "R2" : "R3", "stall cycles",
          32'(stalls), exp_hit ? 32'd0 : 32'd4);
    check(fetch_word == mem_fn(a[31:2]), "R2", "delivered word", fetch_word, mem_fn(a[31:2]));
    check(mem_rd_en == 1'b0, "R4", "no read when ready", 32'(mem_rd_en), 32'd0);
    m_val[idx] = 1'b1;
    m_tag[idx] = a[31:6];
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int st;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 4; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; end
    rst_n = 1'b0;
    fetch_valid = 1'b0;
    fetch_addr  = '0;
    repeat (3) @(negedge clk);
    #2;
    check(fetch_ready == 1'b1, "R8", "ready in reset idle", 32'(fetch_ready), 32'd1);
    check(mem_rd_en == 1'b0, "R8", "no read in reset", 32'(mem_rd_en), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cold lines miss
    fetch(32'h0000_1000, st);
    check(st == 4, "R1", "first fetch after reset misses", 32'(st), 32'd4);
    // R5: rest of block hits
    fetch(32'h0000_1004, st);
    check(st == 0, "R5", "word1 hits", 32'(st), 32'd0);
    fetch(32'h0000_1008, st);
    check(st == 0, "R5", "word2 hits", 32'(st), 32'd0);
    fetch(32'h0000_100C, st);
    check(st == 0, "R5", "word3 hits", 32'(st), 32'd0);
    // R7: low byte bits ignored
    fetch(32'h0000_1007, st);
    check(st == 0 && fetch_word == mem_fn(30'h0000_1004 >> 2), "R7", "unaligned fetch word",
          fetch_word, mem_fn(30'h0000_1004 >> 2));
    // R6: conflict on index 0
    fetch(32'h0000_2000, st);
    check(st == 4, "R6", "conflicting tag misses", 32'(st), 32'd4);
    fetch(32'h0000_1000, st);
    check(st == 4, "R6", "evicted block misses again", 32'(st), 32'd4);
    fetch(32'h0000_1010, st);
    check(st == 4, "R6", "index 1 is a separate line", 32'(st), 32'd4);
    // R9: four resident blocks
    for (int l = 0; l < 4; l++) fetch(32'h0000_3000 + 32'(l * 16), st);
    for (int k = 0; k < 16; k++) begin
      fetch(32'h0000_3000 + 32'(k * 4), st);
      check(st == 0, "R9", "resident word hits", 32'(st), 32'd0);
    end
    // R8: idle cycles
    fetch_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      #2;
      check(fetch_ready == 1'b1, "R8", "ready while idle", 32'(fetch_ready), 32'd1);
      check(mem_rd_en == 1'b0, "R8", "no read while idle", 32'(mem_rd_en), 32'd0);
      @(negedge clk);
    end

    // random mix of hits, conflicts and refills
    for (int n = 0; n < 400; n++) begin
      logic [3:0] t;
      logic [31:0] a;
      t = 4'($urandom % 6);
      a = {22'h0, t, 2'($urandom), 2'($urandom), 2'($urandom)};
      if ($urandom % 5 == 0) begin
        fetch_valid = 1'b0;
        @(negedge clk);
      end
      fetch(a, st);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule